// File: doc/BRIEF.md
# Registered bidirectional bus transceiver

This block links two 8-bit ports, A and B. It can pass data live in either direction, or it can replay a value captured earlier. There are two storage registers. The A-to-B register samples port A on the rising edge of its own clock. The B-to-A register samples port B on the rising edge of a second, independent clock. Both registers load on every rising edge of their clocks, whatever the output controls are set to.

An active-low output enable and a direction input decide which port is driven, if any. With outputs enabled, direction 0 drives port A and direction 1 drives port B. With the enable high, neither port is driven, but both registers still capture. A per-direction source select picks what reaches the driven port: live data from the opposite port, or the stored register contents.

Each bidirectional port is split into an input vector, an output vector and a drive flag, so that it can be synthesized. The output routing is purely combinational.

Top module: `reg_bus_xcvr`

## Requirements
- R1: An active-low asynchronous reset clears both storage registers to zero.
- R2: The A-to-B register loads `a_i` on each rising edge of `clk_ab_i`.
- R3: The B-to-A register loads `b_i` on each rising edge of `clk_ba_i`.
- R4: Register capture happens for every setting of `oe_ni` and `dir_i`, including when both ports are undriven.
- R5: While `oe_ni` is 1, `a_oe_o` and `b_oe_o` are 0 and `a_o` and `b_o` read zero.
- R6: While `oe_ni` is 0, `dir_i` = 0 sets `a_oe_o` = 1 and `b_oe_o` = 0, and `dir_i` = 1 sets `b_oe_o` = 1 and `a_oe_o` = 0. An undriven port output reads zero.
- R7: When port B is driven, `sel_ab_i` = 0 puts `a_i` on `b_o` in the same cycle, and `sel_ab_i` = 1 puts the A-to-B register on `b_o`. The path does not invert.
- R8: When port A is driven, `sel_ba_i` = 0 puts `b_i` on `a_o` in the same cycle, and `sel_ba_i` = 1 puts the B-to-A register on `a_o`. The path does not invert.
- R9: A register keeps its value while its clock has no rising edge, however the selects and data inputs change.
- R10: Both registers can load from their own ports on rising edges that occur together.
- R11: `a_oe_o` and `b_oe_o` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab_i | input | 1 | Capture clock for the A-to-B register, rising edge |
| clk_ba_i | input | 1 | Capture clock for the B-to-A register, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oe_ni | input | 1 | Output enable, active low |
| dir_i | input | 1 | Direction: 0 drives port A, 1 drives port B |
| sel_ab_i | input | 1 | Source for port B: 0 live, 1 stored |
| sel_ba_i | input | 1 | Source for port A: 0 live, 1 stored |
| a_i | input | 8 | Port A input data |
| b_i | input | 8 | Port B input data |
| a_o | output | 8 | Port A output data |
| a_oe_o | output | 1 | Port A drive flag |
| b_o | output | 8 | Port B output data |
| b_oe_o | output | 1 | Port B drive flag |

## Verification
A register that holds a wrong value is hidden while the live path is selected. It shows only once that direction is driven with the stored source selected, and then it appears at once on the driven port. The bench therefore captures data in isolation and reads it back through the stored source. It also toggles the selects with the clock idle to expose a spurious load. Errors in the drive decode or the mux show up in the same cycle as the control change, and every step compares both drive flags and both data outputs.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_W = 8;

  typedef enum logic [1:0] {
    DRV_NONE = 2'b00,
    DRV_A    = 2'b01,
    DRV_B    = 2'b10
  } drive_e;
endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
  import xcvr_pkg::*;
(
  input  logic   oe_ni,
  input  logic   dir_i,
  output drive_e drive_o
);
  always_comb begin
    if (oe_ni)      drive_o = DRV_NONE;
    else if (dir_i) drive_o = DRV_B;
    else            drive_o = DRV_A;
  end
endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux #(
  parameter int unsigned W = 8
) (
  input  logic         en_i,
  input  logic         sel_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] stored_i,
  output logic [W-1:0] out_o
);
  // one identical channel per bit, forced low when the port is undriven
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign out_o[i] = en_i & (sel_i ? stored_i[i] : live_i[i]);
  end
endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk_ab_i,
  input  logic         clk_ba_i,
  input  logic         rst_ni,
  input  logic         oe_ni,
  input  logic         dir_i,
  input  logic         sel_ab_i,
  input  logic         sel_ba_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  output logic [W-1:0] b_o,
  output logic         b_oe_o
);
  logic [W-1:0] q_ab, q_ba;
  drive_e       drive;

  xcvr_store_reg #(.W(W)) u_reg_ab (
    .clk_i(clk_ab_i), .rst_ni(rst_ni), .d_i(a_i), .q_o(q_ab)
  );

  xcvr_store_reg #(.W(W)) u_reg_ba (
    .clk_i(clk_ba_i), .rst_ni(rst_ni), .d_i(b_i), .q_o(q_ba)
  );

  xcvr_drive_ctl u_ctl (
    .oe_ni(oe_ni), .dir_i(dir_i), .drive_o(drive)
  );

  assign a_oe_o = (drive == DRV_A);
  assign b_oe_o = (drive == DRV_B);

  xcvr_path_mux #(.W(W)) u_mux_b (
    .en_i(b_oe_o), .sel_i(sel_ab_i), .live_i(a_i), .stored_i(q_ab), .out_o(b_o)
  );

  xcvr_path_mux #(.W(W)) u_mux_a (
    .en_i(a_oe_o), .sel_i(sel_ba_i), .live_i(b_i), .stored_i(q_ba), .out_o(a_o)
  );
endmodule

// File: rtl/reg_bus_xcvr_chk.sv
module reg_bus_xcvr_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_ab_i,
  input logic         clk_ba_i,
  input logic         rst_ni,
  input logic         oe_ni,
  input logic         dir_i,
  input logic         sel_ab_i,
  input logic         sel_ba_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] a_o,
  input logic         a_oe_o,
  input logic [W-1:0] b_o,
  input logic         b_oe_o,
  input logic [W-1:0] q_ab,
  input logic [W-1:0] q_ba
);
  // R2
  ab_capture_chk: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    rst_ni |=> q_ab == $past(a_i));

  // R3
  ba_capture_chk: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    rst_ni |=> q_ba == $past(b_i));

  always_comb begin
    if (rst_ni) begin
      // R11
      one_driver_chk: assert (!(a_oe_o && b_oe_o));
      // R5
      if (oe_ni) begin
        isolate_chk: assert (!a_oe_o && !b_oe_o && a_o == '0 && b_o == '0);
      end
      // R6
      if (!oe_ni) begin
        dir_decode_chk: assert (a_oe_o == !dir_i && b_oe_o == dir_i);
      end
      // R7
      if (b_oe_o) begin
        b_source_chk: assert (b_o == (sel_ab_i ? q_ab : a_i));
      end
      // R8
      if (a_oe_o) begin
        a_source_chk: assert (a_o == (sel_ba_i ? q_ba : b_i));
      end
    end
  end
endmodule

bind reg_bus_xcvr reg_bus_xcvr_chk #(.W(W)) u_chk (.*);

// File: tb/reg_bus_xcvr_tb.sv
module reg_bus_xcvr_tb;
  localparam int W = 8;

  typedef struct {
    logic [W-1:0] a_o;
    logic         a_oe;
    logic [W-1:0] b_o;
    logic         b_oe;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         clk_ab = 0, clk_ba = 0, rst_n = 0;
  logic         oe_n = 1, dir = 0, sel_ab = 0, sel_ba = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;

  reg_bus_xcvr #(.W(W)) u_dut (
    .clk_ab_i(clk_ab), .clk_ba_i(clk_ba), .rst_ni(rst_n),
    .oe_ni(oe_n), .dir_i(dir), .sel_ab_i(sel_ab), .sel_ba_i(sel_ba),
    .a_i(a_in), .b_i(b_in),
    .a_o(a_out), .a_oe_o(a_oe), .b_o(b_out), .b_oe_o(b_oe)
  );

  exp_t         exp_q[$];
  logic [W-1:0] m_ab = '0, m_ba = '0;
  int           checks = 0, errors = 0;
  bit           done = 0;

  task automatic step(input logic on, input logic d, input logic sab, input logic sba,
                      input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic cab, input logic cba, input string tag);
    exp_t e;
    @(posedge clk);
    #2;
    oe_n = on; dir = d; sel_ab = sab; sel_ba = sba; a_in = a; b_in = b;
    clk_ab = 0; clk_ba = 0;
    #1;
    clk_ab = cab; clk_ba = cba;
    if (cab) m_ab = a;
    if (cba) m_ba = b;
    #2;
    e.a_oe = !on && !d;
    e.b_oe = !on && d;
    e.a_o  = e.a_oe ? (sba ? m_ba : b) : '0;
    e.b_o  = e.b_oe ? (sab ? m_ab : a) : '0;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        checks++;
        if (a_out !== e.a_o || a_oe !== e.a_oe || b_out !== e.b_o || b_oe !== e.b_oe) begin
          errors++;
          $display("FAIL %s: a_o=%h a_oe=%b b_o=%h b_oe=%b expected a_o=%h a_oe=%b b_o=%h b_oe=%b",
                   e.tag, a_out, a_oe, b_out, b_oe, e.a_o, e.a_oe, e.b_o, e.b_oe);
        end
        checks++;
        if (a_oe && b_oe) begin
          errors++;
          $display("FAIL R11: a_oe=%b b_oe=%b expected at most one high", a_oe, b_oe);
        end
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    // clock the registers while reset holds them clear
    #5 clk_ab = 1; clk_ba = 1; a_in = 8'hE7; b_in = 8'h7E;
    #30 rst_n = 1;
    // R1: stored contents read as zero after reset
    step(0, 1, 1, 0, 8'h3C, 8'h00, 0, 0, "R1 stored A-to-B after reset");
    step(0, 0, 0, 1, 8'h00, 8'h3C, 0, 0, "R1 stored B-to-A after reset");
    // R7 / R8 / R6 live transfer both ways
    step(0, 1, 0, 0, 8'h5A, 8'h00, 0, 0, "R7 live A to B");
    step(0, 1, 0, 0, 8'hA5, 8'h0F, 0, 0, "R6 dir=1 drives B only");
    step(0, 0, 0, 0, 8'h00, 8'hC3, 0, 0, "R8 live B to A");
    step(0, 0, 0, 0, 8'h99, 8'h81, 0, 0, "R6 dir=0 drives A only");
    // R4 / R5 store while isolated
    step(1, 1, 1, 1, 8'h11, 8'h00, 1, 0, "R5 isolated capture A");
    step(1, 0, 1, 1, 8'h00, 8'h22, 0, 1, "R4 isolated capture B");
    step(0, 1, 1, 0, 8'hFF, 8'h00, 0, 0, "R2 stored A-to-B readout");
    step(0, 0, 0, 1, 8'h00, 8'hEE, 0, 0, "R3 stored B-to-A readout");
    // R10 both registers load together
    step(1, 0, 0, 0, 8'hAA, 8'h55, 1, 1, "R10 joint capture isolated");
    step(0, 1, 1, 0, 8'h01, 8'h02, 0, 0, "R10 joint capture A side");
    step(0, 0, 0, 1, 8'h03, 8'h04, 0, 0, "R10 joint capture B side");
    // R9 selects toggle with clocks idle
    step(0, 1, 0, 0, 8'h6B, 8'h00, 0, 0, "R9 live while idle");
    step(0, 1, 1, 0, 8'hC4, 8'h00, 0, 0, "R9 stored kept after toggle");
    step(0, 1, 0, 0, 8'h2D, 8'h00, 0, 0, "R9 live again");
    step(0, 1, 1, 0, 8'h77, 8'h00, 0, 0, "R9 stored still kept");
    step(0, 0, 0, 1, 8'h00, 8'h38, 0, 0, "R9 B-to-A kept");
    // R4 capture while driving, including capture of the undriven port
    step(0, 1, 1, 0, 8'h77, 8'h00, 1, 0, "R4 capture while B driven");
    step(0, 1, 0, 1, 8'h12, 8'h9C, 0, 1, "R4 capture B while B driven");
    step(0, 0, 0, 1, 8'h00, 8'h00, 0, 0, "R3 readout captured B");
    // R5 isolation with stored selects set
    step(1, 1, 1, 1, 8'hF0, 8'h0F, 0, 0, "R5 isolated outputs zero");
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule